// File: doc/BRIEF.md
# Output-Compare and PWM Channel

This block is a single compare channel that sits next to a timer's time base. Each cycle it receives the running count, the direction of counting and the time base's update pulse. It compares the count against a 16-bit compare value and drives a reference level according to a 3-bit mode. The mode can set, clear or toggle the reference on a match, force it to a fixed level, freeze it, or produce one of two PWM shapes that depend on the count direction. Each match raises a sticky interrupt flag.

Software writes the compare value through a simple write strobe. When preload is selected, the written value waits in a buffer and becomes active on the next update pulse. When preload is off, the value becomes active on the next cycle. An output stage applies a polarity and gates the result with a channel enable before it reaches the pin.

The mode byte uses fixed bit positions. Bits 6:4 hold the mode code. Bit 3 selects compare preload. Bit 7 and bit 2 are a clear-enable flag and a fast-enable flag. Those two flags, and bits 1:0, are stored and read back but change nothing else.

Top module: `oc_channel`

## Requirements
- R1: Synchronous active-low reset clears the reference, the match flag, the active and buffered compare values and the stored mode byte. With the enable and polarity inputs low, the pin then reads 0.
- R2: With preload off (mode byte bit 3 = 0), a compare write appears in both the active and the buffered compare value one cycle after the write strobe.
- R3: With preload on (bit 3 = 1), a compare write changes only the buffer, and the update pulse copies the buffer into the active value. If a write and an update fall in the same cycle, the newly written value becomes active.
- R4: When the count equals the active compare value, the match flag reads 1 in the next cycle. The flag stays set until the clear input is applied in a cycle without a match; a match in the same cycle as a clear wins.
- R5: Mode code 1 sets the reference to 1 on a match, code 2 clears it to 0 on a match, and code 3 inverts it on a match. Without a match these modes hold the reference. Code 0 (frozen) always holds the reference, even on a match.
- R6: Mode code 4 drives the reference to 0 and code 5 drives it to 1 in the cycle after the mode takes effect, regardless of the count.
- R7: PWM code 6 gives the following reference levels. Counting up (direction input 0): 1 while the count is below the compare value, else 0. Counting down (direction 1): 0 while the count is above the compare value, else 1.
- R8: PWM code 7 gives the following reference levels. Counting up: 0 while the count is below the compare value, else 1. Counting down: 1 while the count is above the compare value, else 0.
- R9: While the channel is enabled, the pin equals the reference XOR the polarity input (polarity 1 makes the pin active-low). While the channel is disabled, the pin equals the polarity input and the reference is reset to 0 at the next edge.
- R10: The mode byte reads back exactly as written one cycle after its write strobe. Bits 7, 2, 1 and 0 have no effect on the reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_val | input | 16 | Current count from the time base |
| cnt_down | input | 1 | 1 when the time base counts down |
| upd_evt | input | 1 | Update pulse from the time base |
| mode_wr | input | 1 | Write strobe for the mode byte |
| mode_wdata | input | 8 | Mode byte to write |
| mode_rdata | output | 8 | Stored mode byte |
| cmp_wr | input | 1 | Write strobe for the compare value |
| cmp_wdata | input | 16 | Compare value to write |
| cmp_buf | output | 16 | Buffered (written) compare value |
| cmp_act | output | 16 | Active compare value used for matching |
| ch_en | input | 1 | Channel enable |
| ch_pol | input | 1 | Output polarity, 1 = active-low |
| hit_clr | input | 1 | Clears the match flag |
| ref_out | output | 1 | Reference level before polarity |
| pin_out | output | 1 | Channel pin after polarity and enable |
| hit_flag | output | 1 | Sticky compare-match flag |

## Verification
Two pairs of events can meet in one cycle. The first pair is a compare write and an update pulse with preload on. The bench raises both strobes together and expects the freshly written value, not the older buffered one, in the active register one cycle later. The second pair is a match and a flag clear. The bench drives the count equal to the active value while holding the clear input, and expects the flag to read 1 afterwards. In a following cycle, a clear without a match must bring the flag back to 0.

// File: rtl/oc_pkg.sv
// Shared definitions for the compare channel: mode codes and mode-byte
// bit positions. Assumes the mode byte layout is fixed by software.
package oc_pkg;

    typedef enum logic [2:0] {
        OC_FROZEN     = 3'd0,
        OC_SET_ON_HIT = 3'd1,
        OC_CLR_ON_HIT = 3'd2,
        OC_TGL_ON_HIT = 3'd3,
        OC_FORCE_LO   = 3'd4,
        OC_FORCE_HI   = 3'd5,
        OC_PWM_A      = 3'd6,
        OC_PWM_B      = 3'd7
    } oc_mode_e;

    localparam int MODE_LSB    = 4;
    localparam int MODE_MSB    = 6;
    localparam int PRELOAD_BIT = 3;
    localparam int FAST_BIT    = 2;
    localparam int CLRE_BIT    = 7;
    localparam int MODE_BYTE_W = 8;

endpackage

// File: rtl/oc_cmp_store.sv
// Compare value storage with an optional preload buffer.
// Assumes: wr is a one-cycle strobe; upd is the time base update pulse.
// The buffer always holds the last written value. The active value follows a
// write at once when preload is off, and takes the buffer (or a value written
// in the same cycle) on an update.
module oc_cmp_store #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         pre_en,
    input  logic         upd,
    output logic [W-1:0] buf_q,
    output logic [W-1:0] act_q
);

    logic [W-1:0] upd_src;

    // Value presented to the active register on an update: a same-cycle write wins.
    always_comb begin
        upd_src = wr ? wdata : buf_q;
    end

    // Buffer register: captures every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else if (wr) begin
            buf_q <= wdata;
        end
    end

    // Active register: direct write without preload, otherwise loaded on update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (wr && !pre_en) begin
            act_q <= wdata;
        end else if (upd) begin
            act_q <= upd_src;
        end
    end

    // R2
    direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !pre_en) |=> (act_q == $past(wdata)));

    // R3
    buffered_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && pre_en && !upd) |=> $stable(act_q));

    // R3
    same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && pre_en && upd) |=> (act_q == $past(wdata)));

endmodule

// File: rtl/oc_ref_gen.sv
// Reference level generator and compare-match flag.
// Assumes cnt and down come from the time base in the same cycle. The
// reference is registered: it reflects the inputs of the previous cycle.
module oc_ref_gen
    import oc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  oc_mode_e     mode,
    input  logic [W-1:0] cnt,
    input  logic         down,
    input  logic [W-1:0] cmp,
    input  logic         flag_clr,
    output logic         ref_q,
    output logic         flag_q
);

    logic hit;
    logic below;
    logic above;
    logic ref_nxt;

    // Magnitude relations between the count and the active compare value.
    always_comb begin
        hit   = (cnt == cmp);
        below = (cnt <  cmp);
        above = (cnt >  cmp);
    end

    // Next reference level per mode.
    always_comb begin
        unique case (mode)
            OC_FROZEN:     ref_nxt = ref_q;
            OC_SET_ON_HIT: ref_nxt = hit ? 1'b1 : ref_q;
            OC_CLR_ON_HIT: ref_nxt = hit ? 1'b0 : ref_q;
            OC_TGL_ON_HIT: ref_nxt = hit ? ~ref_q : ref_q;
            OC_FORCE_LO:   ref_nxt = 1'b0;
            OC_FORCE_HI:   ref_nxt = 1'b1;
            OC_PWM_A:      ref_nxt = down ? ~above : below;
            OC_PWM_B:      ref_nxt = down ? above : ~below;
            default:       ref_nxt = 1'b0;
        endcase
    end

    // Reference register: held low while the channel is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= 1'b0;
        end else if (!en) begin
            ref_q <= 1'b0;
        end else begin
            ref_q <= ref_nxt;
        end
    end

    // Sticky match flag: a match outranks a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (hit) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    // R6
    force_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == OC_FORCE_LO) |=> !ref_q);

    // R6
    force_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == OC_FORCE_HI) |=> ref_q);

    // R5
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == OC_FROZEN) |=> $stable(ref_q));

    // R4
    hit_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == cmp) |=> flag_q);

    // R4
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr) |=> flag_q);

    // R9
    off_ref_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !ref_q);

endmodule

// File: rtl/oc_pin_stage.sv
// Output stage: applies polarity and the channel enable to the reference.
// Assumes the inactive pin level equals the polarity setting.
module oc_pin_stage (
    input  logic ref_in,
    input  logic en,
    input  logic pol,
    output logic pin
);

    // Polarity and gating of the pin level.
    always_comb begin
        pin = en ? (ref_in ^ pol) : pol;
    end

endmodule

// File: rtl/oc_channel.sv
// Output-compare / PWM channel top. Holds the mode byte and wires the
// compare store, reference generator and pin stage. Assumes count,
// direction and update pulse arrive from a time base in the same clock domain.
module oc_channel
    import oc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_down,
    input  logic             upd_evt,
    input  logic             mode_wr,
    input  logic [7:0]       mode_wdata,
    output logic [7:0]       mode_rdata,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    output logic [CNT_W-1:0] cmp_buf,
    output logic [CNT_W-1:0] cmp_act,
    input  logic             ch_en,
    input  logic             ch_pol,
    input  logic             hit_clr,
    output logic             ref_out,
    output logic             pin_out,
    output logic             hit_flag
);

    logic [MODE_BYTE_W-1:0] mode_q;
    oc_mode_e               mode_sel;
    logic                   pre_en;

    // Mode byte register: all bits stored for read-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (mode_wr) begin
            mode_q <= mode_wdata;
        end
    end

    // Field decode of the stored mode byte.
    always_comb begin
        mode_sel = oc_mode_e'(mode_q[MODE_MSB:MODE_LSB]);
        pre_en   = mode_q[PRELOAD_BIT];
    end

    assign mode_rdata = mode_q;

    oc_cmp_store #(.W(CNT_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cmp_wr),
        .wdata  (cmp_wdata),
        .pre_en (pre_en),
        .upd    (upd_evt),
        .buf_q  (cmp_buf),
        .act_q  (cmp_act)
    );

    oc_ref_gen #(.W(CNT_W)) u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ch_en),
        .mode     (mode_sel),
        .cnt      (cnt_val),
        .down     (cnt_down),
        .cmp      (cmp_act),
        .flag_clr (hit_clr),
        .ref_q    (ref_out),
        .flag_q   (hit_flag)
    );

    oc_pin_stage u_pin (
        .ref_in (ref_out),
        .en     (ch_en),
        .pol    (ch_pol),
        .pin    (pin_out)
    );

    // R10
    mode_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (mode_rdata == $past(mode_wdata)));

endmodule

// File: tb/oc_channel_tb.sv
module oc_channel_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int VN = 17;

    // {mode[2:0], down, count[15:0], expected reference}; compare value is 100.
    localparam logic [20:0] VEC [VN] = '{
        {3'd6, 1'b0, 16'd99,  1'b1},
        {3'd6, 1'b0, 16'd100, 1'b0},
        {3'd6, 1'b0, 16'd101, 1'b0},
        {3'd6, 1'b0, 16'd0,   1'b1},
        {3'd6, 1'b1, 16'd101, 1'b0},
        {3'd6, 1'b1, 16'd100, 1'b1},
        {3'd6, 1'b1, 16'd99,  1'b1},
        {3'd7, 1'b0, 16'd99,  1'b0},
        {3'd7, 1'b0, 16'd100, 1'b1},
        {3'd7, 1'b0, 16'd101, 1'b1},
        {3'd7, 1'b1, 16'd101, 1'b1},
        {3'd7, 1'b1, 16'd100, 1'b0},
        {3'd7, 1'b1, 16'd99,  1'b0},
        {3'd4, 1'b0, 16'd99,  1'b0},
        {3'd5, 1'b0, 16'd200, 1'b1},
        {3'd4, 1'b1, 16'd100, 1'b0},
        {3'd5, 1'b1, 16'd100, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cnt_val;
    logic        cnt_down;
    logic        upd_evt;
    logic        mode_wr;
    logic [7:0]  mode_wdata;
    logic [7:0]  mode_rdata;
    logic        cmp_wr;
    logic [15:0] cmp_wdata;
    logic [15:0] cmp_buf;
    logic [15:0] cmp_act;
    logic        ch_en;
    logic        ch_pol;
    logic        hit_clr;
    logic        ref_out;
    logic        pin_out;
    logic        hit_flag;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    oc_channel #(.CNT_W(16)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_val    (cnt_val),
        .cnt_down   (cnt_down),
        .upd_evt    (upd_evt),
        .mode_wr    (mode_wr),
        .mode_wdata (mode_wdata),
        .mode_rdata (mode_rdata),
        .cmp_wr     (cmp_wr),
        .cmp_wdata  (cmp_wdata),
        .cmp_buf    (cmp_buf),
        .cmp_act    (cmp_act),
        .ch_en      (ch_en),
        .ch_pol     (ch_pol),
        .hit_clr    (hit_clr),
        .ref_out    (ref_out),
        .pin_out    (pin_out),
        .hit_flag   (hit_flag)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_mode(input logic [7:0] b);
        mode_wr    = 1'b1;
        mode_wdata = b;
        tick();
        mode_wr    = 1'b0;
    endtask

    task automatic set_cmp(input logic [15:0] v, input logic with_upd);
        cmp_wr    = 1'b1;
        cmp_wdata = v;
        upd_evt   = with_upd;
        tick();
        cmp_wr    = 1'b0;
        upd_evt   = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cnt_val = 16'hAAAA; cnt_down = 1'b0; upd_evt = 1'b0;
        mode_wr = 1'b0; mode_wdata = 8'h00; cmp_wr = 1'b0; cmp_wdata = 16'h0;
        ch_en = 1'b0; ch_pol = 1'b0; hit_clr = 1'b0;
        @(negedge clk);
        tick(); tick();
        // R1 reset state
        chk("R1 ref", {15'd0, ref_out}, 16'd0);
        chk("R1 pin", {15'd0, pin_out}, 16'd0);
        chk("R1 flag", {15'd0, hit_flag}, 16'd0);
        chk("R1 cmp_act", cmp_act, 16'd0);
        chk("R1 cmp_buf", cmp_buf, 16'd0);
        chk("R1 mode", {8'd0, mode_rdata}, 16'd0);
        rst_n = 1'b1;
        ch_en = 1'b1;
        tick();
        set_cmp(16'd100, 1'b0);

        // Table walk: R6, R7, R8 with compare value 100, polarity 0
        for (int i = 0; i < VN; i++) begin
            logic [2:0] m;
            string tg;
            m = VEC[i][20:18];
            tg = (m == 3'd6) ? "R7" : ((m == 3'd7) ? "R8" : "R6");
            set_mode({1'b0, m, 4'b0000});
            cnt_down = VEC[i][17];
            cnt_val  = VEC[i][16:1];
            tick();
            chk({tg, " ref"}, {15'd0, ref_out}, {15'd0, VEC[i][0]});
            chk({tg, " pin"}, {15'd0, pin_out}, {15'd0, VEC[i][0]});
        end
        cnt_down = 1'b0;
        cnt_val  = 16'hAAAA;

        // R2 direct write
        set_cmp(16'h1234, 1'b0);
        chk("R2 act", cmp_act, 16'h1234);
        chk("R2 buf", cmp_buf, 16'h1234);

        // R3 preload: buffered write, update copy, same-cycle write and update
        set_mode(8'h08);
        set_cmp(16'h0200, 1'b0);
        chk("R3 act held", cmp_act, 16'h1234);
        chk("R3 buf", cmp_buf, 16'h0200);
        upd_evt = 1'b1; tick(); upd_evt = 1'b0;
        chk("R3 act on update", cmp_act, 16'h0200);
        set_cmp(16'h0300, 1'b1);
        chk("R3 same-cycle write wins", cmp_act, 16'h0300);

        // R4 match flag
        hit_clr = 1'b1; tick(); hit_clr = 1'b0;
        chk("R4 cleared", {15'd0, hit_flag}, 16'd0);
        cnt_val = 16'h0300; tick();
        chk("R4 set on match", {15'd0, hit_flag}, 16'd1);
        cnt_val = 16'hAAAA; tick();
        chk("R4 sticky", {15'd0, hit_flag}, 16'd1);
        hit_clr = 1'b1; tick();
        chk("R4 clear", {15'd0, hit_flag}, 16'd0);
        cnt_val = 16'h0300; tick();
        chk("R4 match beats clear", {15'd0, hit_flag}, 16'd1);
        cnt_val = 16'hAAAA; tick(); hit_clr = 1'b0;
        chk("R4 clear after", {15'd0, hit_flag}, 16'd0);

        // R5 set / clear / toggle on match, frozen hold
        set_mode(8'h40); tick();
        chk("R5 start low", {15'd0, ref_out}, 16'd0);
        set_mode(8'h10);
        tick();
        chk("R5 set no match", {15'd0, ref_out}, 16'd0);
        cnt_val = 16'h0300; tick();
        chk("R5 set on match", {15'd0, ref_out}, 16'd1);
        cnt_val = 16'hAAAA; tick();
        chk("R5 set hold", {15'd0, ref_out}, 16'd1);
        set_mode(8'h20); tick();
        chk("R5 clear no match", {15'd0, ref_out}, 16'd1);
        cnt_val = 16'h0300; tick();
        chk("R5 clear on match", {15'd0, ref_out}, 16'd0);
        cnt_val = 16'hAAAA;
        set_mode(8'h30);
        cnt_val = 16'h0300; tick();
        chk("R5 toggle up", {15'd0, ref_out}, 16'd1);
        cnt_val = 16'hAAAA; tick();
        chk("R5 toggle hold", {15'd0, ref_out}, 16'd1);
        cnt_val = 16'h0300; tick();
        chk("R5 toggle down", {15'd0, ref_out}, 16'd0);
        cnt_val = 16'hAAAA;
        set_mode(8'h50); tick();
        set_mode(8'h00);
        cnt_val = 16'h0300; tick();
        chk("R5 frozen ref", {15'd0, ref_out}, 16'd1);
        chk("R5 frozen pin", {15'd0, pin_out}, 16'd1);

        // R9 polarity and enable gating
        cnt_val = 16'hAAAA;
        ch_pol = 1'b1; tick();
        chk("R9 active-low pin", {15'd0, pin_out}, 16'd0);
        ch_en = 1'b0; tick();
        chk("R9 disabled ref", {15'd0, ref_out}, 16'd0);
        chk("R9 disabled pin", {15'd0, pin_out}, 16'd1);
        set_mode(8'h50); tick();
        chk("R9 disabled forced ref", {15'd0, ref_out}, 16'd0);
        ch_en = 1'b1; tick();
        chk("R9 re-enabled ref", {15'd0, ref_out}, 16'd1);
        chk("R9 re-enabled pin", {15'd0, pin_out}, 16'd0);
        ch_pol = 1'b0;

        // R10 flag bits stored, no effect on PWM
        set_mode(8'hE7);
        chk("R10 readback", {8'd0, mode_rdata}, 16'h00E7);
        cnt_val = 16'h02FF; tick();
        chk("R10 pwm below", {15'd0, ref_out}, 16'd1);
        cnt_val = 16'h0300; tick();
        chk("R10 pwm equal", {15'd0, ref_out}, 16'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule